// File: doc/BRIEF.md
# Four-Channel DMA Controller Register Port

This block is the control side of a four-channel direct memory access controller. Software reaches it through an 8-bit register port with a 4-bit offset. Each channel keeps a 16-bit base and current address and a 16-bit base and current count. These are 16 bits wide but pass through an 8-bit port, so a shared byte-pointer flip-flop picks the low or the high byte and toggles on every access to a channel register.

A separate narrow port loads an 8-bit page value for each channel. The page forms the upper part of the memory address. Stepping the address never carries into the page, so a transfer stays inside one 64K window.

Peripherals ask for service on per-channel request lines. In single mode the block grants one transfer per acknowledge. The acknowledge comes with the full memory address, a direction strobe and a terminal-count flag. Counts are held as the number of transfers minus one. The data path and any sharing of the bus with a host processor are outside this block.

Top module: `dmac4_regport`

## Requirements
- R1: After reset every channel is masked, the byte pointer selects the low byte, all current registers read 0, the status byte reads 0x00, `reg_rdata` is 0 and no `dack` is given to any request.
- R2: A channel's current address (offset 2n) and count (offset 2n+1) are written and read low byte first, then high byte. The pointer toggles on each read or write to offsets 0x0 to 0x7. A write of any value to offset 0xC makes the next access use the low byte. Read data appears on `reg_rdata` one cycle after the access.
- R3: A loaded count C gives exactly C+1 transfers. `tc` is high together with the acknowledge of the last of them, so a count of 0 gives a single transfer.
- R4: Each transfer drives `mem_addr` = {page, current address}. After the transfer the current address goes up by one (mode bit 5 = 0) or down by one (mode bit 5 = 1). It wraps between 0xFFFF and 0x0000 and leaves the page unchanged.
- R5: When a channel reaches terminal count without auto-init, its count reads 0xFFFF, its status flag is set and the channel masks itself, so later requests on it get no acknowledge.
- R6: When mode bit 4 (auto-init) is set, terminal count reloads the current address and count from the base values written earlier, and the channel stays unmasked.
- R7: A write to offset 0xA selects the channel with data bits 1:0; bit 2 = 1 masks that channel and bit 2 = 0 unmasks it. A write to 0xE unmasks all channels. A write to 0xF sets each channel's mask from data bit n.
- R8: A write to offset 0xB stores the mode of the channel given by bits 1:0. Bits 3:2 = 01 gives memory writes (`mem_wr` high during the acknowledge), and 10 gives memory reads (`mem_rd`). Bits 7:6 = 11 (cascade) stop the channel from ever being acknowledged.
- R9: In single mode, `dack` goes high for one cycle per transfer, one cycle after the request is sampled, with at least one idle cycle between transfers. At most one bit is high, and when several channels ask at once the lowest-numbered one wins.
- R10: A read at offset 0x8 returns {pending requests in bits 7:4, terminal-count flags in bits 3:0} and clears the flags. A write at 0x8 with bit 2 set stops all new acknowledges until that bit is written back to 0.
- R11: A write to offset 0x9 with bit 2 set raises a software request on the channel in bits 1:0, and bit 2 clear drops it. The request is serviced like a request line and is cleared at that channel's terminal count.
- R12: A write to offset 0xD (master clear) masks every channel and clears the byte pointer, the status flags, the software requests and the disable bit. Reads of 0xD return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access in this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| pg_we | input | 1 | Page register write strobe |
| pg_ch | input | 2 | Channel whose page is written |
| pg_data | input | 8 | Page value |
| dreq | input | 4 | Per-channel transfer requests |
| dack | output | 4 | Per-channel acknowledges, one transfer each |
| mem_addr | output | 24 | Page and current address of the transfer |
| mem_wr | output | 1 | Transfer writes memory |
| mem_rd | output | 1 | Transfer reads memory |
| tc | output | 1 | Last transfer of the programmed count |

## Verification
The assertions assume that software never touches a channel's address or count while that channel is being served, and that only one register access happens per cycle. The masking check also assumes that the mask state seen one cycle before an acknowledge is the state that produced it. The stimulus keeps within these limits. It programs channels only while they are masked or idle, and it raises request lines for single cycles separated by an idle cycle, except in one directed run where a request is held to show the gap between transfers. Random addresses, counts, pages and step directions are drawn from a fixed seed. Directed cases cover both 64K wraps, zero counts, auto-init reload and master clear.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  // mode byte bits 7:2; bits 1:0 select the channel on write
  typedef struct packed {
    logic [1:0] xmode;     // 11 = cascade
    logic       dec;       // 1 = address steps down
    logic       autoinit;  // reload base values at terminal count
    logic [1:0] xtype;     // 01 = to memory, 10 = from memory
  } chmode_t;

  localparam logic [1:0] XMODE_CASCADE  = 2'b11;
  localparam logic [1:0] XTYPE_TO_MEM   = 2'b01;
  localparam logic [1:0] XTYPE_FROM_MEM = 2'b10;

  localparam logic [3:0] OFS_CMDSTAT = 4'h8;
  localparam logic [3:0] OFS_SWREQ   = 4'h9;
  localparam logic [3:0] OFS_MASK1   = 4'hA;
  localparam logic [3:0] OFS_MODE    = 4'hB;
  localparam logic [3:0] OFS_PTRCLR  = 4'hC;
  localparam logic [3:0] OFS_MCLR    = 4'hD;
  localparam logic [3:0] OFS_UNMASK  = 4'hE;
  localparam logic [3:0] OFS_MASKALL = 4'hF;
endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
  import dmac_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           sel,
  input  logic           we,
  input  logic [3:0]     addr,
  output logic [NCH-1:0] ld_addr,
  output logic [NCH-1:0] ld_cnt,
  output logic           chreg_acc,
  output logic           chreg_rd,
  output logic           cmd_we,
  output logic           stat_rd,
  output logic           swreq_we,
  output logic           mask1_we,
  output logic           mode_we,
  output logic           ptrclr_we,
  output logic           mclr_we,
  output logic           mclr_rd,
  output logic           unmask_we,
  output logic           maskall_we
);
  localparam logic [4:0] CHREG_END = 5'(2 * NCH);

  logic wr, rd;
  assign wr = sel && we;
  assign rd = sel && !we;

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ld
      assign ld_addr[i] = wr && (addr == 4'(2 * i));
      assign ld_cnt[i]  = wr && (addr == 4'(2 * i + 1));
    end
  endgenerate

  assign chreg_acc  = sel && ({1'b0, addr} < CHREG_END);
  assign chreg_rd   = rd && ({1'b0, addr} < CHREG_END);
  assign cmd_we     = wr && (addr == OFS_CMDSTAT);
  assign stat_rd    = rd && (addr == OFS_CMDSTAT);
  assign swreq_we   = wr && (addr == OFS_SWREQ);
  assign mask1_we   = wr && (addr == OFS_MASK1);
  assign mode_we    = wr && (addr == OFS_MODE);
  assign ptrclr_we  = wr && (addr == OFS_PTRCLR);
  assign mclr_we    = wr && (addr == OFS_MCLR);
  assign mclr_rd    = rd && (addr == OFS_MCLR);
  assign unmask_we  = wr && (addr == OFS_UNMASK);
  assign maskall_we = wr && (addr == OFS_MASKALL);
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclr,
  input  logic              ld_addr,
  input  logic              ld_cnt,
  input  logic              ptr_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              mode_we,
  input  chmode_t           mode_in,
  input  logic              mask_set,
  input  logic              mask_clr,
  input  logic              sreq_set,
  input  logic              sreq_clr,
  input  logic              pg_we,
  input  logic [PAGE_W-1:0] pg_din,
  input  logic              stat_clr,
  input  logic              xfer,
  input  logic              dreq,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] cur_cnt,
  output logic [PAGE_W-1:0] page,
  output chmode_t           mode,
  output logic              masked,
  output logic              sreq,
  output logic              tc_flag,
  output logic              eligible,
  output logic              last
);
  logic [ADDR_W-1:0] base_a, base_c, nxt_a, nxt_c, nxt_ba, nxt_bc;

  assign last     = (cur_cnt == '0);
  assign eligible = (dreq || sreq) && !masked && (mode.xmode != XMODE_CASCADE);

  always_comb begin
    nxt_a  = cur_addr;
    nxt_ba = base_a;
    if (ld_addr) begin
      if (ptr_hi) begin
        nxt_a[ADDR_W-1:BYTE_W]  = wdata;
        nxt_ba[ADDR_W-1:BYTE_W] = wdata;
      end else begin
        nxt_a[BYTE_W-1:0]  = wdata;
        nxt_ba[BYTE_W-1:0] = wdata;
      end
    end else if (xfer) begin
      if (last && mode.autoinit) nxt_a = base_a;
      else if (mode.dec)         nxt_a = cur_addr - 1'b1;
      else                       nxt_a = cur_addr + 1'b1;
    end
  end

  always_comb begin
    nxt_c  = cur_cnt;
    nxt_bc = base_c;
    if (ld_cnt) begin
      if (ptr_hi) begin
        nxt_c[ADDR_W-1:BYTE_W]  = wdata;
        nxt_bc[ADDR_W-1:BYTE_W] = wdata;
      end else begin
        nxt_c[BYTE_W-1:0]  = wdata;
        nxt_bc[BYTE_W-1:0] = wdata;
      end
    end else if (xfer) begin
      nxt_c = (last && mode.autoinit) ? base_c : cur_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
      base_a   <= '0;
      base_c   <= '0;
      page     <= '0;
      mode     <= '0;
    end else begin
      cur_addr <= nxt_a;
      cur_cnt  <= nxt_c;
      base_a   <= nxt_ba;
      base_c   <= nxt_bc;
      if (pg_we)   page <= pg_din;
      if (mode_we) mode <= mode_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      masked  <= 1'b1;
      sreq    <= 1'b0;
      tc_flag <= 1'b0;
    end else begin
      if (mask_set)      masked <= 1'b1;
      else if (mask_clr) masked <= 1'b0;
      if (sreq_set)      sreq <= 1'b1;
      else if (sreq_clr) sreq <= 1'b0;
      if (stat_clr)      tc_flag <= 1'b0;
      if (xfer && last) begin
        tc_flag <= 1'b1;
        sreq    <= 1'b0;
        if (!mode.autoinit) masked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmac_prio.sv
module dmac_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) grant = N'(1) << i;
    end
  end
  assign any = |req;
endmodule

// File: rtl/dmac4_regport.sv
module dmac4_regport
  import dmac_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int PAGE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_sel,
  input  logic                     reg_we,
  input  logic [3:0]               reg_addr,
  input  logic [7:0]               reg_wdata,
  output logic [7:0]               reg_rdata,
  input  logic                     pg_we,
  input  logic [$clog2(NCH)-1:0]   pg_ch,
  input  logic [PAGE_W-1:0]        pg_data,
  input  logic [NCH-1:0]           dreq,
  output logic [NCH-1:0]           dack,
  output logic [PAGE_W+ADDR_W-1:0] mem_addr,
  output logic                     mem_wr,
  output logic                     mem_rd,
  output logic                     tc
);
  localparam int CH_W = $clog2(NCH);

  logic [NCH-1:0] ld_addr, ld_cnt;
  logic chreg_acc, chreg_rd, cmd_we, stat_rd, swreq_we, mask1_we, mode_we;
  logic ptrclr_we, mclr_we, mclr_rd, unmask_we, maskall_we;

  dmac_decode #(.NCH(NCH)) u_dec (
    .sel(reg_sel), .we(reg_we), .addr(reg_addr),
    .ld_addr(ld_addr), .ld_cnt(ld_cnt),
    .chreg_acc(chreg_acc), .chreg_rd(chreg_rd),
    .cmd_we(cmd_we), .stat_rd(stat_rd), .swreq_we(swreq_we),
    .mask1_we(mask1_we), .mode_we(mode_we), .ptrclr_we(ptrclr_we),
    .mclr_we(mclr_we), .mclr_rd(mclr_rd), .unmask_we(unmask_we),
    .maskall_we(maskall_we)
  );

  logic ptr_q, cmd_dis_q;

  always_ff @(posedge clk) begin
    if (rst || mclr_we || ptrclr_we) ptr_q <= 1'b0;
    else if (chreg_acc)              ptr_q <= ~ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst || mclr_we) cmd_dis_q <= 1'b0;
    else if (cmd_we)    cmd_dis_q <= reg_wdata[2];
  end

  logic [ADDR_W-1:0] ch_addr [NCH];
  logic [ADDR_W-1:0] ch_cnt  [NCH];
  logic [PAGE_W-1:0] ch_page [NCH];
  chmode_t           ch_mode [NCH];
  logic [NCH-1:0]    mask_v, sreq_v, tc_v, elig_v, last_v, grant, xfer_v;
  logic              any_req, go;
  logic [CH_W-1:0]   wch;

  assign wch = reg_wdata[CH_W-1:0];
  assign go  = !(|dack) && any_req && !cmd_dis_q;

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      logic hit, m_set, m_clr;
      assign hit   = (wch == CH_W'(i));
      assign m_set = (mask1_we && hit && reg_wdata[2]) || (maskall_we && reg_wdata[i]);
      assign m_clr = (mask1_we && hit && !reg_wdata[2]) || unmask_we
                   || (maskall_we && !reg_wdata[i]);
      assign xfer_v[i] = go && grant[i];

      dmac_chan #(.PAGE_W(PAGE_W)) u_chan (
        .clk(clk), .rst(rst), .mclr(mclr_we),
        .ld_addr(ld_addr[i]), .ld_cnt(ld_cnt[i]), .ptr_hi(ptr_q),
        .wdata(reg_wdata),
        .mode_we(mode_we && hit), .mode_in(chmode_t'(reg_wdata[7:2])),
        .mask_set(m_set), .mask_clr(m_clr),
        .sreq_set(swreq_we && hit && reg_wdata[2]),
        .sreq_clr(swreq_we && hit && !reg_wdata[2]),
        .pg_we(pg_we && (pg_ch == CH_W'(i))), .pg_din(pg_data),
        .stat_clr(stat_rd), .xfer(xfer_v[i]), .dreq(dreq[i]),
        .cur_addr(ch_addr[i]), .cur_cnt(ch_cnt[i]), .page(ch_page[i]),
        .mode(ch_mode[i]), .masked(mask_v[i]), .sreq(sreq_v[i]),
        .tc_flag(tc_v[i]), .eligible(elig_v[i]), .last(last_v[i])
      );
    end
  endgenerate

  dmac_prio #(.N(NCH)) u_prio (.req(elig_v), .grant(grant), .any(any_req));

  // granted channel's transfer attributes
  logic [PAGE_W+ADDR_W-1:0] g_addr;
  logic                     g_last;
  logic [1:0]               g_type;

  always_comb begin
    g_addr = '0;
    g_last = 1'b0;
    g_type = 2'b00;
    for (int k = 0; k < NCH; k++) begin
      if (grant[k]) begin
        g_addr = {ch_page[k], ch_addr[k]};
        g_last = last_v[k];
        g_type = ch_mode[k].xtype;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dack     <= '0;
      mem_addr <= '0;
      mem_wr   <= 1'b0;
      mem_rd   <= 1'b0;
      tc       <= 1'b0;
    end else if (go) begin
      dack     <= grant;
      mem_addr <= g_addr;
      mem_wr   <= (g_type == XTYPE_TO_MEM);
      mem_rd   <= (g_type == XTYPE_FROM_MEM);
      tc       <= g_last;
    end else begin
      dack   <= '0;
      mem_wr <= 1'b0;
      mem_rd <= 1'b0;
      tc     <= 1'b0;
    end
  end

  // read-back path
  logic [CH_W-1:0]   rch;
  logic [ADDR_W-1:0] rword;
  logic [7:0]        stat_byte;

  assign rch       = reg_addr[CH_W:1];
  assign rword     = reg_addr[0] ? ch_cnt[rch] : ch_addr[rch];
  assign stat_byte = 8'({(dreq | sreq_v), tc_v});

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (chreg_rd) begin
      reg_rdata <= ptr_q ? rword[ADDR_W-1:BYTE_W] : rword[BYTE_W-1:0];
    end else if (stat_rd) begin
      reg_rdata <= stat_byte;
    end else if (mclr_rd) begin
      reg_rdata <= '0;
    end
  end
endmodule

// File: rtl/dmac4_regport_chk.sv
module dmac4_regport_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           reg_sel,
  input logic           reg_we,
  input logic [3:0]     reg_addr,
  input logic [NCH-1:0] dack,
  input logic           tc,
  input logic [NCH-1:0] mask_v,
  input logic           ptr_q,
  input logic           cmd_dis_q
);
  a_r9_dack_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dack));

  a_r9_idle_between: assert property (@(posedge clk) disable iff (rst)
    (dack != '0) |=> (dack == '0));

  a_r3_tc_with_ack: assert property (@(posedge clk) disable iff (rst)
    tc |-> (dack != '0));

  a_r7_masked_no_ack: assert property (@(posedge clk) disable iff (rst)
    (dack != '0) |-> (($past(mask_v) & dack) == '0));

  a_r10_disable_blocks: assert property (@(posedge clk) disable iff (rst)
    cmd_dis_q |=> (dack == '0));

  a_r2_ptr_clear: assert property (@(posedge clk) disable iff (rst)
    (reg_sel && reg_we && reg_addr == 4'hC) |=> !ptr_q);

  a_r12_master_clear: assert property (@(posedge clk) disable iff (rst)
    (reg_sel && reg_we && reg_addr == 4'hD) |=> (mask_v == '1 && !ptr_q && !cmd_dis_q));
endmodule

bind dmac4_regport dmac4_regport_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
  .reg_addr(reg_addr), .dack(dack), .tc(tc), .mask_v(mask_v),
  .ptr_q(ptr_q), .cmd_dis_q(cmd_dis_q)
);

// File: tb/dmac4_regport_test.sv
`timescale 1ns/1ps
module dmac4_regport_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        pg_we = 1'b0;
  logic [1:0]  pg_ch = '0;
  logic [7:0]  pg_data = '0;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack;
  logic [23:0] mem_addr;
  logic        mem_wr, mem_rd, tc;

  int n_cmp = 0, n_bad = 0;

  dmac4_regport uut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pg_we(pg_we), .pg_ch(pg_ch), .pg_data(pg_data),
    .dreq(dreq), .dack(dack), .mem_addr(mem_addr),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .tc(tc)
  );

  always #10 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic logic [15:0] f_step(input logic [15:0] a, input bit dec);
    return dec ? a - 16'd1 : a + 16'd1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_sel = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_word(input logic [3:0] a, output logic [15:0] w);
    logic [7:0] lo, hi;
    wr_reg(4'hC, 8'h00);
    rd_reg(a, lo);
    rd_reg(a, hi);
    w = {hi, lo};
  endtask

  task automatic program_ch(input int ch, input logic [15:0] a, input logic [15:0] c);
    wr_reg(4'hC, 8'h00);
    wr_reg(4'(2 * ch), a[7:0]);
    wr_reg(4'(2 * ch), a[15:8]);
    wr_reg(4'(2 * ch + 1), c[7:0]);
    wr_reg(4'(2 * ch + 1), c[15:8]);
  endtask

  task automatic set_page(input int ch, input logic [7:0] p);
    @(negedge clk);
    pg_we = 1'b1; pg_ch = 2'(ch); pg_data = p;
    @(negedge clk);
    pg_we = 1'b0;
  endtask

  // one-cycle request; outputs of the resulting transfer are captured
  task automatic pulse(input logic [3:0] r, output logic [3:0] ack,
                       output logic [23:0] ma, output logic t,
                       output logic mw, output logic mr);
    @(negedge clk);
    dreq = r;
    @(negedge clk);
    dreq = '0;
    ack = dack; ma = mem_addr; t = tc; mw = mem_wr; mr = mem_rd;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    logic [3:0]  ack;
    logic [23:0] ma;
    logic        t, mw, mr;
    int          cnt_ack;

    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 rdata", 32'(reg_rdata), 32'h0);
    chk("R1 dack", 32'(dack), 32'h0);
    rd_reg(4'h8, b);
    chk("R1 status", 32'(b), 32'h0);
    rd_reg(4'h0, b);
    chk("R1 addr0 low byte", 32'(b), 32'h0);
    wr_reg(4'hB, 8'h44);
    pulse(4'b0001, ack, ma, t, mw, mr);
    chk("R1 masked after reset", 32'(ack), 32'h0);

    // R2 byte pointer, random values
    for (int k = 0; k < 8; k++) begin
      int ch;
      logic [15:0] ra, rc;
      ch = k % 4;
      ra = 16'($urandom);
      rc = 16'($urandom);
      program_ch(ch, ra, rc);
      rd_word(4'(2 * ch), w);
      chk("R2 address readback", 32'(w), 32'(ra));
      rd_word(4'(2 * ch + 1), w);
      chk("R2 count readback", 32'(w), 32'(rc));
    end
    wr_reg(4'hC, 8'h00);
    wr_reg(4'h4, 8'h5C);
    wr_reg(4'hC, 8'hFF);
    wr_reg(4'h4, 8'hA7);
    rd_word(4'h4, w);
    chk("R2 pointer clear low byte", 32'(w[7:0]), 32'hA7);

    // R3 R4 R5 R8 increment with 64K wrap, memory write
    program_ch(0, 16'hFFFE, 16'd2);
    set_page(0, 8'h10);
    wr_reg(4'hB, 8'h44);
    wr_reg(4'hA, 8'h00);
    pulse(4'b0001, ack, ma, t, mw, mr);
    chk("R9 ack ch0", 32'(ack), 32'h1);
    chk("R4 addr 1", 32'(ma), 32'h10FFFE);
    chk("R8 mem_wr", 32'({mw, mr}), 32'h2);
    chk("R3 no tc 1", 32'(t), 32'h0);
    pulse(4'b0001, ack, ma, t, mw, mr);
    chk("R4 addr 2", 32'(ma), 32'h10FFFF);
    chk("R3 no tc 2", 32'(t), 32'h0);
    pulse(4'b0001, ack, ma, t, mw, mr);
    chk("R4 wrap keeps page", 32'(ma), 32'h100000);
    chk("R3 tc on third", 32'(t), 32'h1);
    rd_word(4'h1, w);
    chk("R5 count ffff", 32'(w), 32'hFFFF);
    rd_reg(4'h8, b);
    chk("R10 status tc bit", 32'(b), 32'h01);
    rd_reg(4'h8, b);
    chk("R10 status cleared by read", 32'(b), 32'h00);
    pulse(4'b0001, ack, ma, t, mw, mr);
    chk("R5 self masked", 32'(ack), 32'h0);

    // R4 R8 decrement with wrap, memory read
    program_ch(1, 16'h0001, 16'd2);
    set_page(1, 8'h33);
    wr_reg(4'hB, 8'h69);
    wr_reg(4'hA, 8'h01);
    pulse(4'b0010, ack, ma, t, mw, mr);
    chk("R4 dec addr 1", 32'(ma), 32'h330001);
    chk("R8 mem_rd", 32'({mw, mr}), 32'h1);
    pulse(4'b0010, ack, ma, t, mw, mr);
    chk("R4 dec addr 2", 32'(ma), 32'h330000);
    pulse(4'b0010, ack, ma, t, mw, mr);
    chk("R4 dec wrap", 32'(ma), 32'h33FFFF);
    chk("R3 dec tc", 32'(t), 32'h1);
    rd_reg(4'h8, b);

    // R3 zero count means one transfer
    program_ch(2, 16'h0400, 16'd0);
    wr_reg(4'hB, 8'h46);
    wr_reg(4'hA, 8'h02);
    pulse(4'b0100, ack, ma, t, mw, mr);
    chk("R3 zero count tc", 32'({ack, t}), 32'h9);
    pulse(4'b0100, ack, ma, t, mw, mr);
    chk("R3 zero count one transfer", 32'(ack), 32'h0);
    rd_reg(4'h8, b);

    // R6 auto-init
    program_ch(3, 16'h1230, 16'd1);
    set_page(3, 8'h5A);
    wr_reg(4'hB, 8'h57);
    wr_reg(4'hA, 8'h03);
    pulse(4'b1000, ack, ma, t, mw, mr);
    chk("R6 first", 32'({ma, t}), 32'({24'h5A1230, 1'b0}));
    pulse(4'b1000, ack, ma, t, mw, mr);
    chk("R6 second tc", 32'({ma, t}), 32'({24'h5A1231, 1'b1}));
    rd_word(4'h6, w);
    chk("R6 address reloaded", 32'(w), 32'h1230);
    rd_word(4'h7, w);
    chk("R6 count reloaded", 32'(w), 32'h0001);
    pulse(4'b1000, ack, ma, t, mw, mr);
    chk("R6 still unmasked", 32'({ack, ma}), 32'({4'b1000, 24'h5A1230}));

    // R8 cascade never acknowledged
    wr_reg(4'hB, 8'hC3);
    pulse(4'b1000, ack, ma, t, mw, mr);
    chk("R8 cascade no ack", 32'(ack), 32'h0);
    wr_reg(4'hB, 8'h47);

    // R7 mask registers
    for (int c = 0; c < 4; c++) program_ch(c, 16'h0000, 16'd100);
    wr_reg(4'hF, 8'h0F);
    wr_reg(4'hA, 8'h01);
    pulse(4'b0010, ack, ma, t, mw, mr);
    chk("R7 single unmask", 32'(ack), 32'h2);
    wr_reg(4'hA, 8'h05);
    pulse(4'b0010, ack, ma, t, mw, mr);
    chk("R7 single mask", 32'(ack), 32'h0);
    wr_reg(4'hF, 8'h0B);
    pulse(4'b1111, ack, ma, t, mw, mr);
    chk("R7 all-mask write", 32'(ack), 32'h4);
    wr_reg(4'hE, 8'h00);
    pulse(4'b1000, ack, ma, t, mw, mr);
    chk("R7 clear all masks", 32'(ack), 32'h8);

    // R9 priority and spacing
    pulse(4'b0110, ack, ma, t, mw, mr);
    chk("R9 lowest wins", 32'(ack), 32'h2);
    @(negedge clk);
    dreq = 4'b0100;
    @(negedge clk); chk("R9 held req ack", 32'(dack), 32'h4);
    @(negedge clk); chk("R9 idle gap", 32'(dack), 32'h0);
    @(negedge clk); chk("R9 held req ack again", 32'(dack), 32'h4);
    @(negedge clk); chk("R9 idle gap again", 32'(dack), 32'h0);
    dreq = '0;
    @(negedge clk);

    // R10 disable bit
    wr_reg(4'h8, 8'h04);
    pulse(4'b0001, ack, ma, t, mw, mr);
    chk("R10 disabled", 32'(ack), 32'h0);
    wr_reg(4'h8, 8'h00);
    pulse(4'b0001, ack, ma, t, mw, mr);
    chk("R10 re-enabled", 32'(ack), 32'h1);

    // R11 software request
    wr_reg(4'hF, 8'h0F);
    program_ch(2, 16'h0800, 16'd1);
    wr_reg(4'hB, 8'h46);
    wr_reg(4'hA, 8'h02);
    rd_reg(4'h8, b);
    wr_reg(4'h9, 8'h06);
    cnt_ack = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (dack == 4'b0100) cnt_ack++;
    end
    chk("R11 two transfers", 32'(cnt_ack), 32'd2);
    rd_reg(4'h8, b);
    chk("R11 request cleared at tc", 32'(b), 32'h04);
    wr_reg(4'h9, 8'h05);
    rd_reg(4'h8, b);
    chk("R10 pending bit", 32'(b), 32'h20);
    wr_reg(4'h9, 8'h01);
    rd_reg(4'h8, b);
    chk("R11 request dropped", 32'(b), 32'h00);
    wr_reg(4'h9, 8'h05);

    // R12 master clear
    wr_reg(4'hE, 8'h00);
    wr_reg(4'h8, 8'h04);
    wr_reg(4'hC, 8'h00);
    wr_reg(4'h0, 8'h11);
    wr_reg(4'hD, 8'h00);
    rd_reg(4'h0, b);
    chk("R12 pointer cleared", 32'(b), 32'h11);
    rd_reg(4'h8, b);
    chk("R12 status and request cleared", 32'(b), 32'h00);
    rd_reg(4'hD, b);
    chk("R12 read zero", 32'(b), 32'h00);
    pulse(4'b0001, ack, ma, t, mw, mr);
    chk("R12 masks set", 32'(ack), 32'h0);
    wr_reg(4'hA, 8'h00);
    pulse(4'b0001, ack, ma, t, mw, mr);
    chk("R12 disable cleared", 32'(ack), 32'h1);

    // random runs against the model: R3 R4 R5
    for (int it = 0; it < 24; it++) begin
      int          ch;
      logic [15:0] a, c;
      logic [7:0]  pg;
      bit          dec;
      ch  = int'($urandom % 4);
      a   = 16'($urandom);
      c   = 16'($urandom % 4);
      dec = bit'($urandom % 2);
      pg  = 8'($urandom);
      wr_reg(4'hF, 8'h0F);
      program_ch(ch, a, c);
      set_page(ch, pg);
      wr_reg(4'hB, 8'(8'h44 | (dec ? 8'h20 : 8'h00) | ch));
      wr_reg(4'hA, 8'(ch));
      for (int k = 0; k <= int'(c); k++) begin
        pulse(4'(1 << ch), ack, ma, t, mw, mr);
        chk("R9 random ack", 32'(ack), 32'(1 << ch));
        chk("R4 random addr", 32'(ma), 32'({pg, a}));
        chk("R3 random tc", 32'(t), 32'(k == int'(c)));
        a = f_step(a, dec);
      end
      rd_word(4'(2 * ch), w);
      chk("R4 random final addr", 32'(w), 32'(a));
      rd_word(4'(2 * ch + 1), w);
      chk("R5 random count", 32'(w), 32'hFFFF);
      rd_reg(4'h8, b);
      chk("R5 random status", 32'(b), 32'(1 << ch));
      pulse(4'(1 << ch), ack, ma, t, mw, mr);
      chk("R5 random masked", 32'(ack), 32'h0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule